// File: doc/BRIEF.md
# USB PHY Configuration Bring-Up Sequencer

This block is a small hardware state machine that configures a high-speed USB PHY after reset, with no processor involved. A start pulse makes it request the three trim values (termination, timing select and drive current) from a fuse or non-volatile memory port. It builds the first configuration word from a built-in default. When the trim set is usable, the trim fields take the fused values. When it is not, the disconnect-threshold field is forced to its maximum instead.

It writes the first configuration word at offset 0x0 and the second at offset 0x4 over a one-cycle write strobe. It then programs up to two internal PHY parameters indirectly through the second word. Each parameter takes four writes: latch the address, drop the address strobe, merge the data, drop the data strobe. The block keeps a shadow copy of the second word, so every read-modify-write is done without a read port. When the last write is done, a done flag rises and stays high until the next start.

Top module: `phy_cfg_seq`

## Requirements
- R1: After reset, and while idle, `nvm_req`, `wr_en` and `done` are low; `wr_addr` and `wr_data` are zero whenever `wr_en` is low.
- R2: A `start` sampled while idle or done raises `nvm_req` (and drops `done`) one cycle later. `nvm_req` then stays high until a cycle in which `nvm_ack` is sampled high.
- R3: The trim set is usable when `nvm_err` is low and at least one trim value is nonzero. The first word is then 0x92316680 with bits 31:28 replaced by `trim_hs_i`, bits 15:12 replaced by `trim_sel_t` and bits 7:6 replaced by `trim_rterm`.
- R4: When every trim value is zero, or `nvm_err` is high with the acknowledge, the first word is 0x92316680 with bits 27:26 forced to 2'b11 and all other bits unchanged.
- R5: The cycle after the acknowledge, one write goes to address 0x0 with the first word. The next cycle, one write goes to address 0x4 with 0x00000106. All later writes go to address 0x4.
- R6: Address step: the shadow word has bits 27:16 replaced by the 12-bit register number and bit 28 set. The next write is the same word with bit 28 cleared.
- R7: Data step: inside bits 23:16, only the bits of the field mask msb..lsb are replaced by (value << lsb) masked, and bit 29 is set. Bits 23:16 outside the mask are kept. The next write clears bit 29.
- R8: Parameters follow one another with no gap. By default, parameter 0 is register 10, bit 6, value 1, and parameter 1 is register 10, bit 5, value 1. With NUM_PARAMS = 0, no indirect writes happen.
- R9: `done` rises the cycle after the last write and holds without further writes. `nvm_ack` has no effect while done.
- R10: A `start` pulse while a sequence is running is ignored, and the write stream continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted when idle or done |
| nvm_ack | input | 1 | Trim read complete |
| nvm_err | input | 1 | Trim read failed (qualifies nvm_ack) |
| trim_rterm | input | 2 | Termination trim |
| trim_sel_t | input | 4 | Timing-select trim |
| trim_hs_i | input | 4 | Drive-current trim |
| nvm_req | output | 1 | Trim read request |
| wr_en | output | 1 | Single-cycle register write strobe |
| wr_addr | output | ADDR_W | Register offset |
| wr_data | output | 32 | Register write data |
| done | output | 1 | Sequence complete, held until next start |

## Verification
`nvm_req` is due one cycle after `start` is sampled. The first-word write is due one cycle after `nvm_ack` is sampled, and every later write follows in the next cycle. `done` is due one cycle after the final write.

The bench drives inputs on falling edges. On every falling edge it compares all outputs of two instances against a behavioural model: the default instance and one built with NUM_PARAMS = 0. The model holds a queue of expected writes for each instance and pops one entry per cycle. An early, late, missing or extra write therefore shows up in the exact cycle where it happens.

// File: rtl/phy_cfg_pkg.sv
package phy_cfg_pkg;

  localparam int DATA_W = 32;
  localparam int MAX_IND = 2;

  // first configuration word field positions
  localparam int HSI_LSB   = 28;
  localparam int HSI_W     = 4;
  localparam int DISC_LSB  = 26;
  localparam int DISC_W    = 2;
  localparam int SELT_LSB  = 12;
  localparam int SELT_W    = 4;
  localparam int RTERM_LSB = 6;
  localparam int RTERM_W   = 2;

  // second configuration word indirect-access fields
  localparam int IND_ADR_LSB = 16;
  localparam int IND_ADR_W   = 12;
  localparam int IND_DAT_LSB = 16;
  localparam int IND_DAT_W   = 8;
  localparam int IND_ADR_STB = 28;
  localparam int IND_DAT_STB = 29;

  typedef struct packed {
    logic [IND_ADR_W-1:0] reg_no;
    logic [2:0]           msb;
    logic [2:0]           lsb;
    logic [IND_DAT_W-1:0] value;
  } ind_param_t;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_FETCH,
    SQ_WORD0,
    SQ_WORD1,
    SQ_IND,
    SQ_DONE
  } seq_state_t;

endpackage

// File: rtl/phy_cfg_trim_merge.sv
module phy_cfg_trim_merge
  import phy_cfg_pkg::*;
#(
  parameter logic [DATA_W-1:0] WORD0_DEF = 32'h9231_6680
) (
  input  logic [RTERM_W-1:0] rterm,
  input  logic [SELT_W-1:0]  sel_t,
  input  logic [HSI_W-1:0]   hs_i,
  input  logic               rd_err,
  output logic [DATA_W-1:0]  word0
);

  logic usable;

  assign usable = !rd_err && ((rterm != '0) || (sel_t != '0) || (hs_i != '0));

  always_comb begin
    word0 = WORD0_DEF;
    if (usable) begin
      word0[HSI_LSB   +: HSI_W]   = hs_i;
      word0[SELT_LSB  +: SELT_W]  = sel_t;
      word0[RTERM_LSB +: RTERM_W] = rterm;
    end else begin
      word0[DISC_LSB +: DISC_W] = '1;
    end
  end

endmodule

// File: rtl/phy_cfg_step_gen.sv
module phy_cfg_step_gen
  import phy_cfg_pkg::*;
(
  input  logic [DATA_W-1:0] shadow,
  input  ind_param_t        prm,
  input  logic [1:0]        step,
  output logic [DATA_W-1:0] word
);

  logic [IND_DAT_W-1:0] fmask;
  logic [IND_DAT_W-1:0] fdata;

  assign fmask = (8'hFF << prm.lsb) & (8'hFF >> (3'd7 - prm.msb));
  assign fdata = (prm.value << prm.lsb) & fmask;

  always_comb begin
    word = shadow;
    unique case (step)
      2'd0: begin
        word[IND_ADR_LSB +: IND_ADR_W] = prm.reg_no;
        word[IND_ADR_STB]              = 1'b1;
      end
      2'd1: word[IND_ADR_STB] = 1'b0;
      2'd2: begin
        word[IND_DAT_LSB +: IND_DAT_W] =
          (shadow[IND_DAT_LSB +: IND_DAT_W] & ~fmask) | fdata;
        word[IND_DAT_STB] = 1'b1;
      end
      default: word[IND_DAT_STB] = 1'b0;
    endcase
  end

endmodule

// File: rtl/phy_cfg_seq.sv
module phy_cfg_seq
  import phy_cfg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [DATA_W-1:0] WORD0_DEF = 32'h9231_6680,
  parameter logic [DATA_W-1:0] WORD1_DEF = 32'h0000_0106,
  parameter int NUM_PARAMS = 2,
  parameter ind_param_t [MAX_IND-1:0] IND_PARAMS = {
    ind_param_t'{reg_no: 12'd10, msb: 3'd5, lsb: 3'd5, value: 8'd1},
    ind_param_t'{reg_no: 12'd10, msb: 3'd6, lsb: 3'd6, value: 8'd1}
  }
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  nvm_ack,
  input  logic                  nvm_err,
  input  logic [RTERM_W-1:0]    trim_rterm,
  input  logic [SELT_W-1:0]     trim_sel_t,
  input  logic [HSI_W-1:0]      trim_hs_i,
  output logic                  nvm_req,
  output logic                  wr_en,
  output logic [ADDR_W-1:0]     wr_addr,
  output logic [DATA_W-1:0]     wr_data,
  output logic                  done
);

  localparam int IDX_W = (MAX_IND > 1) ? $clog2(MAX_IND) : 1;
  localparam int LAST_IDX = (NUM_PARAMS > 0) ? NUM_PARAMS - 1 : 0;
  localparam logic [ADDR_W-1:0] ADDR_WORD0 = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_WORD1 = ADDR_W'(4);

  seq_state_t        state_q, state_d;
  logic [DATA_W-1:0] word0_q, word0_calc;
  logic              word0_en;
  logic [DATA_W-1:0] shadow_q, shadow_d;
  logic              shadow_en;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [1:0]        step_q, step_d;
  logic              ctr_en;
  logic [DATA_W-1:0] step_word;
  ind_param_t        cur_prm;

  phy_cfg_trim_merge #(.WORD0_DEF(WORD0_DEF)) u_merge (
    .rterm (trim_rterm),
    .sel_t (trim_sel_t),
    .hs_i  (trim_hs_i),
    .rd_err(nvm_err),
    .word0 (word0_calc)
  );

  generate
    if (NUM_PARAMS > 0) begin : g_ind
      assign cur_prm = IND_PARAMS[idx_q];
    end else begin : g_no_ind
      assign cur_prm = '0;
    end
  endgenerate

  phy_cfg_step_gen u_step (
    .shadow(shadow_q),
    .prm   (cur_prm),
    .step  (step_q),
    .word  (step_word)
  );

  // next-state logic
  always_comb begin
    state_d   = state_q;
    word0_en  = 1'b0;
    shadow_en = 1'b0;
    shadow_d  = shadow_q;
    ctr_en    = 1'b0;
    idx_d     = idx_q;
    step_d    = step_q;
    unique case (state_q)
      SQ_IDLE, SQ_DONE: if (start) state_d = SQ_FETCH;
      SQ_FETCH: if (nvm_ack) begin
        word0_en = 1'b1;
        state_d  = SQ_WORD0;
      end
      SQ_WORD0: state_d = SQ_WORD1;
      SQ_WORD1: begin
        shadow_en = 1'b1;
        shadow_d  = WORD1_DEF;
        ctr_en    = 1'b1;
        idx_d     = '0;
        step_d    = 2'd0;
        state_d   = (NUM_PARAMS == 0) ? SQ_DONE : SQ_IND;
      end
      SQ_IND: begin
        shadow_en = 1'b1;
        shadow_d  = step_word;
        ctr_en    = 1'b1;
        step_d    = step_q + 2'd1;
        if (step_q == 2'd3) begin
          if (idx_q == IDX_W'(LAST_IDX)) state_d = SQ_DONE;
          else idx_d = idx_q + IDX_W'(1);
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SQ_IDLE;
      word0_q  <= '0;
      shadow_q <= '0;
      idx_q    <= '0;
      step_q   <= '0;
    end else begin
      state_q <= state_d;
      if (word0_en)  word0_q  <= word0_calc;
      if (shadow_en) shadow_q <= shadow_d;
      if (ctr_en) begin
        idx_q  <= idx_d;
        step_q <= step_d;
      end
    end
  end

  // outputs
  always_comb begin
    nvm_req = (state_q == SQ_FETCH);
    done    = (state_q == SQ_DONE);
    wr_en   = 1'b0;
    wr_addr = '0;
    wr_data = '0;
    unique case (state_q)
      SQ_WORD0: begin
        wr_en   = 1'b1;
        wr_addr = ADDR_WORD0;
        wr_data = word0_q;
      end
      SQ_WORD1: begin
        wr_en   = 1'b1;
        wr_addr = ADDR_WORD1;
        wr_data = WORD1_DEF;
      end
      SQ_IND: begin
        wr_en   = 1'b1;
        wr_addr = ADDR_WORD1;
        wr_data = step_word;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/phy_cfg_seq_chk.sv
module phy_cfg_seq_chk
  import phy_cfg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              nvm_ack,
  input logic              nvm_req,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              done
);

  // R1: the write bus is quiet whenever no write is strobed
  assert_quiet_bus_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> (wr_addr == '0 && wr_data == '0));

  // R2: the read request holds until acknowledged
  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (nvm_req && !nvm_ack) |=> nvm_req);

  // R5: the first word is followed at once by the second word
  assert_word_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(0)) |=> (wr_en && wr_addr == ADDR_W'(4)));

  // R5: the first word only comes right after an acknowledge
  assert_word0_after_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(0)) |-> $past(nvm_ack && nvm_req));

  // R6: address strobe drops on the next write
  assert_adr_stb_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(4) && wr_data[IND_ADR_STB])
      |=> (wr_en && !wr_data[IND_ADR_STB]));

  // R7: data strobe drops on the next write
  assert_dat_stb_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(4) && wr_data[IND_DAT_STB])
      |=> (wr_en && !wr_data[IND_DAT_STB]));

  // R9: done is held until start
  assert_done_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && !wr_en));

  // R9: done rises only right after a write
  assert_done_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(wr_en));

  // R9: no write while done
  always @(posedge clk) begin
    if (rst_n) begin
      assert_no_write_done_R9: assert (!(wr_en && done));
    end
  end

endmodule

bind phy_cfg_seq phy_cfg_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .nvm_ack(nvm_ack),
  .nvm_req(nvm_req),
  .wr_en  (wr_en),
  .wr_addr(wr_addr),
  .wr_data(wr_data),
  .done   (done)
);

// File: tb/test_phy_cfg_seq.sv
module test_phy_cfg_seq;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic        nvm_ack;
  logic        nvm_err;
  logic [1:0]  trim_rterm;
  logic [3:0]  trim_sel_t;
  logic [3:0]  trim_hs_i;

  logic        req_a, wen_a, done_a;
  logic [7:0]  addr_a;
  logic [31:0] data_a;
  logic        req_b, wen_b, done_b;
  logic [7:0]  addr_b;
  logic [31:0] data_b;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  phy_cfg_seq i_phy_cfg_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .nvm_ack(nvm_ack), .nvm_err(nvm_err),
    .trim_rterm(trim_rterm), .trim_sel_t(trim_sel_t), .trim_hs_i(trim_hs_i),
    .nvm_req(req_a), .wr_en(wen_a), .wr_addr(addr_a), .wr_data(data_a), .done(done_a)
  );

  phy_cfg_seq #(.NUM_PARAMS(0)) i_phy_cfg_seq_noind (
    .clk(clk), .rst_n(rst_n), .start(start), .nvm_ack(nvm_ack), .nvm_err(nvm_err),
    .trim_rterm(trim_rterm), .trim_sel_t(trim_sel_t), .trim_hs_i(trim_hs_i),
    .nvm_req(req_b), .wr_en(wen_b), .wr_addr(addr_b), .wr_data(data_b), .done(done_b)
  );

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // full output comparison of one instance in one cycle
  task automatic cmp_all(string tag, bit b, logic req, logic wen, logic [7:0] adr,
                         logic [31:0] dat, logic dn);
    if (!b) begin
      cmp({tag, " req"},  32'(req_a),  32'(req));
      cmp({tag, " wen"},  32'(wen_a),  32'(wen));
      cmp({tag, " addr"}, 32'(addr_a), 32'(adr));
      cmp({tag, " data"}, data_a,      dat);
      cmp({tag, " done"}, 32'(done_a), 32'(dn));
    end else begin
      cmp({tag, " B req"},  32'(req_b),  32'(req));
      cmp({tag, " B wen"},  32'(wen_b),  32'(wen));
      cmp({tag, " B addr"}, 32'(addr_b), 32'(adr));
      cmp({tag, " B data"}, data_b,      dat);
      cmp({tag, " B done"}, 32'(done_b), 32'(dn));
    end
  endtask

  function automatic logic [31:0] model_word0(logic [1:0] rt, logic [3:0] st,
                                              logic [3:0] hi, logic err);
    logic [31:0] w = 32'h9231_6680;
    if (!err && (rt != 0 || st != 0 || hi != 0)) begin
      w[31:28] = hi;
      w[15:12] = st;
      w[7:6]   = rt;
    end else begin
      w[27:26] = 2'b11;
    end
    return w;
  endfunction

  task automatic run_seq(logic [1:0] rt, logic [3:0] st, logic [3:0] hi,
                         logic err, int delay, bit poke);
    logic [7:0]  qa_addr[$];
    logic [31:0] qa_data[$];
    string       qa_tag[$];
    logic [31:0] sh;
    string       t0;
    t0 = (!err && (rt != 0 || st != 0 || hi != 0)) ? "R3" : "R4";
    qa_addr.push_back(8'h00); qa_data.push_back(model_word0(rt, st, hi, err)); qa_tag.push_back(t0);
    sh = 32'h0000_0106;
    qa_addr.push_back(8'h04); qa_data.push_back(sh); qa_tag.push_back("R5");
    for (int p = 0; p < 2; p++) begin
      int bitpos = (p == 0) ? 6 : 5;
      sh[27:16] = 12'd10; sh[28] = 1'b1;
      qa_addr.push_back(8'h04); qa_data.push_back(sh); qa_tag.push_back("R6 R8");
      sh[28] = 1'b0;
      qa_addr.push_back(8'h04); qa_data.push_back(sh); qa_tag.push_back("R6");
      sh[16 + bitpos] = 1'b1; sh[29] = 1'b1;
      qa_addr.push_back(8'h04); qa_data.push_back(sh); qa_tag.push_back("R7 R8");
      sh[29] = 1'b0;
      qa_addr.push_back(8'h04); qa_data.push_back(sh); qa_tag.push_back("R7");
    end

    @(negedge clk);
    trim_rterm = rt; trim_sel_t = st; trim_hs_i = hi; nvm_err = err;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int d = 0; d < delay; d++) begin
      cmp_all("R2 wait", 0, 1, 0, 0, 0, 0);
      cmp_all("R2 wait", 1, 1, 0, 0, 0, 0);
      @(negedge clk);
    end
    cmp_all("R2 ack", 0, 1, 0, 0, 0, 0);
    cmp_all("R2 ack", 1, 1, 0, 0, 0, 0);
    nvm_ack = 1'b1;
    @(negedge clk);
    nvm_ack = 1'b0;
    for (int j = 0; j < qa_addr.size(); j++) begin
      cmp_all(qa_tag[j], 0, 0, 1, qa_addr[j], qa_data[j], 0);
      if (j < 2) cmp_all(qa_tag[j], 1, 0, 1, qa_addr[j], qa_data[j], 0);
      else       cmp_all("R8 skip", 1, 0, 0, 0, 0, 1);
      start = (poke && j == 1);   // R10: start while busy
      @(negedge clk);
      start = 1'b0;
    end
    for (int k = 0; k < 3; k++) begin
      cmp_all("R9 hold", 0, 0, 0, 0, 0, 1);
      cmp_all("R9 hold", 1, 0, 0, 0, 0, 1);
      nvm_ack = (k == 1);         // R9: stray acknowledge has no effect
      @(negedge clk);
      nvm_ack = 1'b0;
    end
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; nvm_ack = 1'b0; nvm_err = 1'b0;
    trim_rterm = '0; trim_sel_t = '0; trim_hs_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cmp_all("R1 reset", 0, 0, 0, 0, 0, 0);
    cmp_all("R1 reset", 1, 0, 0, 0, 0, 0);
    nvm_ack = 1'b1;               // R1: acknowledge while idle changes nothing
    @(negedge clk);
    nvm_ack = 1'b0;
    cmp_all("R1 idle", 0, 0, 0, 0, 0, 0);
    cmp_all("R1 idle", 1, 0, 0, 0, 0, 0);

    run_seq(2'd0, 4'd0, 4'd0, 1'b0, 0, 1'b0);   // unprogrammed -> fallback
    run_seq(2'd1, 4'd5, 4'hA, 1'b0, 3, 1'b1);   // full trim, busy start
    run_seq(2'd0, 4'd0, 4'hF, 1'b0, 1, 1'b0);   // one nonzero field
    run_seq(2'd3, 4'hC, 4'h7, 1'b1, 2, 1'b0);   // read error -> fallback
    run_seq(2'd2, 4'd0, 4'd0, 1'b0, 0, 1'b1);   // only termination trimmed

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      finished = 1;
      miscompares++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule